// File: doc/BRIEF.md
# Staged Synthesizer Divider Control

This block is the digital half of a frequency synthesizer loop. It keeps two free-running modulus counters. The reference counter counts ticks of the reference clock enable and divides them by N+1. The feedback counter counts ticks of the oscillator feedback enable and divides them by M+1. Each counter gives a one-cycle pulse at its terminal count, and the two pulses go to an external phase comparator. When the loop is locked, the output frequency is (M+1)/(N+1) times the reference frequency.

Software writes new M and N values through a small register port. These values wait in staging registers. They reach the counters only when the center-frequency DAC code register is written. A change of frequency is therefore done in two steps: write M and/or N, then write the DAC code. A committed value does not cut the count that is in progress. The counter uses the new modulus from its next terminal count, so the output never has a runt period.

The control is a staging state machine with four states:
- `ST_CLEAN`: nothing pending.
- `ST_M_PEND`: M pending.
- `ST_N_PEND`: N pending.
- `ST_BOTH_PEND`: both pending.

Its transitions are:
- An M write moves CLEAN to M_PEND, and N_PEND to BOTH.
- An N write moves CLEAN to N_PEND, and M_PEND to BOTH.
- A DAC write moves every state back to CLEAN and commits whatever was pending.

Each counter has its own two-state machine:
- `CNT_RUN` moves to `CNT_ARMED` on a commit.
- `CNT_ARMED` moves back to `CNT_RUN` at the terminal count where it loads the held value.

Top module: `synth_div_ctrl`

## Requirements
- R1: After reset, every readable register reads 0 and both pulse outputs are low while their tick enables are low. The readable registers are staged M (address 0), staged N (1), DAC code (2), active M (4), active N (5) and status (6). `dac_code` is also 0.
- R2: With active N, `ref_pulse` goes high for one clock once every N+1 cycles in which `ref_en` is high. With `ref_en` high on alternate cycles, the pulses are 2(N+1) clocks apart.
- R3: With active M, `fb_pulse` goes high for one clock once every M+1 cycles in which `fb_en` is high.
- R4: A write to address 0 (M) or address 1 (N) does the following:
  - It updates that staged readback.
  - It sets a status bit at address 6: bit 0 for M pending, bit 1 for N pending.
  - It leaves the active readbacks (addresses 4 and 5) and the pulse spacing unchanged.
- R5: A write to address 2 (DAC code) moves the pending values toward the counters. The period in progress completes with the old modulus. The new modulus governs every period after the next terminal count. Until that terminal count, the active readback still shows the old value.
- R6: A write to address 2 with nothing pending updates `dac_code` and its readback, and leaves both active moduli and pulse spacing unchanged.
- R7: When several writes to M (or N) come before one DAC write, the last value written is the one committed.
- R8: Writes to addresses 3 through 7 change no register. Reads of addresses 3 and 7 return 0.
- R9: A write to address 2 returns the status register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| ref_en | input | 1 | Reference tick enable |
| fb_en | input | 1 | Oscillator feedback tick enable |
| ref_pulse | output | 1 | Reference divider terminal pulse |
| fb_pulse | output | 1 | Feedback divider terminal pulse |
| dac_code | output | DATA_W | Current center-frequency DAC code |

## Verification
Some properties are checked by the assertions on every cycle:
- The counters stay within their modulus.
- A modulus changes only at a terminal count.
- A commit happens only on a DAC write.
- The DAC code follows its write.
- The status returns to clean after a DAC write.
- A staged value holds while it is not written.

Other behaviours need the bench's scenarios, which measure pulse spacing through a scoreboard:
- The absolute divide ratios.
- The absence of a runt period across a commit.
- Last-write-wins staging.
- Ignored addresses.
- The doubled spacing under gated ticks.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_M_STG = 3'd0;
    localparam logic [ADDR_W-1:0] A_N_STG = 3'd1;
    localparam logic [ADDR_W-1:0] A_DAC   = 3'd2;
    localparam logic [ADDR_W-1:0] A_M_ACT = 3'd4;
    localparam logic [ADDR_W-1:0] A_N_ACT = 3'd5;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd6;

    localparam int NUM_DIV = 2;
    localparam int IDX_REF = 0;
    localparam int IDX_FB  = 1;

    typedef enum logic [1:0] {
        ST_CLEAN     = 2'd0,
        ST_M_PEND    = 2'd1,
        ST_N_PEND    = 2'd2,
        ST_BOTH_PEND = 2'd3
    } stage_state_e;

    typedef enum logic {
        CNT_RUN   = 1'b0,
        CNT_ARMED = 1'b1
    } cnt_state_e;

endpackage

// File: rtl/synth_div_regs.sv
module synth_div_regs
    import synth_div_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] m_stg,
    output logic [DATA_W-1:0] n_stg,
    output logic [DATA_W-1:0] dac_q,
    output logic              pend_m,
    output logic              pend_n,
    output logic              commit_m,
    output logic              commit_n
);

    stage_state_e state, state_nx;
    logic wr_m, wr_n, wr_dac;

    assign wr_m   = reg_we && (reg_addr == A_M_STG);
    assign wr_n   = reg_we && (reg_addr == A_N_STG);
    assign wr_dac = reg_we && (reg_addr == A_DAC);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CLEAN;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAN: begin
                if (wr_m)      state_nx = ST_M_PEND;
                else if (wr_n) state_nx = ST_N_PEND;
            end
            ST_M_PEND: begin
                if (wr_dac)    state_nx = ST_CLEAN;
                else if (wr_n) state_nx = ST_BOTH_PEND;
            end
            ST_N_PEND: begin
                if (wr_dac)    state_nx = ST_CLEAN;
                else if (wr_m) state_nx = ST_BOTH_PEND;
            end
            ST_BOTH_PEND: begin
                if (wr_dac)    state_nx = ST_CLEAN;
            end
            default: state_nx = ST_CLEAN;
        endcase
    end

    // Outputs of the staging machine
    always_comb begin
        pend_m = 1'b0;
        pend_n = 1'b0;
        unique case (state)
            ST_CLEAN:     ;
            ST_M_PEND:    pend_m = 1'b1;
            ST_N_PEND:    pend_n = 1'b1;
            ST_BOTH_PEND: begin
                pend_m = 1'b1;
                pend_n = 1'b1;
            end
            default: ;
        endcase
        commit_m = wr_dac && pend_m;
        commit_n = wr_dac && pend_n;
    end

    // Staging and DAC code storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stg <= '0;
            n_stg <= '0;
            dac_q <= '0;
        end else begin
            if (wr_m)   m_stg <= reg_wdata;
            if (wr_n)   n_stg <= reg_wdata;
            if (wr_dac) dac_q <= reg_wdata;
        end
    end

    assert_commit_needs_dac_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_m || commit_n) |-> (reg_we && reg_addr == A_DAC));

    assert_status_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dac |=> (!pend_m && !pend_n));

    assert_dac_follows_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dac |=> (dac_q == $past(reg_wdata)));

    assert_stage_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_m |=> $stable(m_stg));

endmodule

// File: rtl/synth_div_counter.sv
module synth_div_counter
    import synth_div_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              load_req,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] modulus,
    output logic              pulse
);

    cnt_state_e        state, state_nx;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] held;
    logic              wrap;

    assign wrap = tick_en && (count == modulus);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CNT_RUN;
        else        state <= state_nx;
    end

    // Transitions: a load arriving on a wrap cycle waits for the next wrap
    always_comb begin
        state_nx = state;
        unique case (state)
            CNT_RUN:   if (load_req)          state_nx = CNT_ARMED;
            CNT_ARMED: if (wrap && !load_req) state_nx = CNT_RUN;
            default:   state_nx = CNT_RUN;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            held    <= '0;
            modulus <= '0;
            pulse   <= 1'b0;
        end else begin
            pulse <= wrap;
            if (load_req) held <= load_val;
            if (tick_en) begin
                if (wrap) count <= '0;
                else      count <= count + 1'b1;
            end
            if (wrap && state == CNT_ARMED) modulus <= held;
        end
    end

    assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= modulus);

    assert_modulus_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_en && count == modulus) |=> $stable(modulus));

    assert_pulse_from_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && count == modulus) |=> pulse);

    assert_armed_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CNT_ARMED && tick_en && count == modulus && !load_req) |=> state == CNT_RUN);

endmodule

// File: rtl/synth_div_ctrl.sv
module synth_div_ctrl
    import synth_div_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ref_en,
    input  logic              fb_en,
    output logic              ref_pulse,
    output logic              fb_pulse,
    output logic [DATA_W-1:0] dac_code
);

    localparam int PAD_W = DATA_W - 2;

    logic [DATA_W-1:0] m_stg, n_stg, dac_q;
    logic              pend_m, pend_n, commit_m, commit_n;

    logic [NUM_DIV-1:0]             tick;
    logic [NUM_DIV-1:0]             load;
    logic [NUM_DIV-1:0]             pul;
    logic [NUM_DIV-1:0][DATA_W-1:0] val;
    logic [NUM_DIV-1:0][DATA_W-1:0] act;

    synth_div_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .m_stg    (m_stg),
        .n_stg    (n_stg),
        .dac_q    (dac_q),
        .pend_m   (pend_m),
        .pend_n   (pend_n),
        .commit_m (commit_m),
        .commit_n (commit_n)
    );

    assign tick[IDX_REF] = ref_en;
    assign tick[IDX_FB]  = fb_en;
    assign load[IDX_REF] = commit_n;
    assign load[IDX_FB]  = commit_m;
    assign val[IDX_REF]  = n_stg;
    assign val[IDX_FB]   = m_stg;

    generate
        for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
            synth_div_counter #(.DATA_W(DATA_W)) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick_en (tick[g]),
                .load_req(load[g]),
                .load_val(val[g]),
                .modulus (act[g]),
                .pulse   (pul[g])
            );
        end
    endgenerate

    assign ref_pulse = pul[IDX_REF];
    assign fb_pulse  = pul[IDX_FB];
    assign dac_code  = dac_q;

    always_comb begin
        unique case (reg_addr)
            A_M_STG: reg_rdata = m_stg;
            A_N_STG: reg_rdata = n_stg;
            A_DAC:   reg_rdata = dac_q;
            A_M_ACT: reg_rdata = act[IDX_FB];
            A_N_ACT: reg_rdata = act[IDX_REF];
            A_STAT:  reg_rdata = {{PAD_W{1'b0}}, pend_n, pend_m};
            default: reg_rdata = '0;
        endcase
    end

    assert_active_m_needs_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_m && !$past(commit_m) && !commit_m && u_regs.state == ST_CLEAN && g_div[IDX_FB].u_cnt.state == CNT_RUN)
            |=> $stable(act[IDX_FB]));

endmodule

// File: tb/synth_div_ctrl_test.sv
module synth_div_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int WATCHDOG = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         ref_base = 1'b0;
    logic         fb_en = 1'b0;
    logic         gate_mode = 1'b0;
    logic         tog = 1'b0;
    logic         ref_en;
    logic         ref_pulse, fb_pulse;
    logic [W-1:0] dac_code;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int    period;
        string tag;
    } exp_t;

    exp_t fb_q[$];
    exp_t ref_q[$];
    int   fb_last = 0;
    int   ref_last = 0;

    assign ref_en = ref_base && (gate_mode ? tog : 1'b1);

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_div_ctrl #(.DATA_W(W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ref_en   (ref_en),
        .fb_en    (fb_en),
        .ref_pulse(ref_pulse),
        .fb_pulse (fb_pulse),
        .dac_code (dac_code)
    );

    always @(negedge clk) tog <= ~tog;

    // Monitor: measures pulse spacing and compares it with the scoreboard
    always @(negedge clk) begin
        cyc++;
        if (fb_pulse) begin
            if (fb_q.size() > 0) begin
                exp_t e;
                e = fb_q.pop_front();
                checks++;
                if (cyc - fb_last != e.period) begin
                    failures++;
                    $display("FAIL %s fb spacing actual=%0d expected=%0d", e.tag, cyc - fb_last, e.period);
                end
            end
            fb_last = cyc;
        end
        if (ref_pulse) begin
            if (ref_q.size() > 0) begin
                exp_t e;
                e = ref_q.pop_front();
                checks++;
                if (cyc - ref_last != e.period) begin
                    failures++;
                    $display("FAIL %s ref spacing actual=%0d expected=%0d", e.tag, cyc - ref_last, e.period);
                end
            end
            ref_last = cyc;
        end
        if (cyc > WATCHDOG && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input int exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, int'(reg_rdata), exp);
    endtask

    task automatic wait_pulse(input bit fb);
        do @(negedge clk); while (!(fb ? fb_pulse : ref_pulse));
    endtask

    task automatic push(input bit fb, input int p, input string tag);
        exp_t e;
        e.period = p;
        e.tag = tag;
        if (fb) fb_q.push_back(e);
        else    ref_q.push_back(e);
    endtask

    task automatic drain();
        while (fb_q.size() != 0 || ref_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ref_pulse", int'(ref_pulse), 0);
        check("R1 fb_pulse", int'(fb_pulse), 0);
        rst_n = 1'b1;
        rd(3'd0, 0, "R1 m staged");
        rd(3'd1, 0, "R1 n staged");
        rd(3'd2, 0, "R1 dac");
        rd(3'd4, 0, "R1 m active");
        rd(3'd5, 0, "R1 n active");
        rd(3'd6, 0, "R1 status");
        check("R1 dac_code", int'(dac_code), 0);

        // R4: staging alone does not reach the counters
        wr(3'd0, 8'd9);
        wr(3'd1, 8'd4);
        rd(3'd0, 9, "R4 m staged");
        rd(3'd1, 4, "R4 n staged");
        rd(3'd6, 3, "R4 status both pending");
        rd(3'd4, 0, "R4 m active held");
        rd(3'd5, 0, "R4 n active held");

        // R5/R9: DAC write commits; counters idle so active waits for a terminal count
        wr(3'd2, 8'h5A);
        rd(3'd6, 0, "R9 status clear");
        check("R6 dac_code", int'(dac_code), 'h5A);
        rd(3'd4, 0, "R5 active waits for wrap");

        ref_base = 1'b1;
        fb_en = 1'b1;
        repeat (30) @(negedge clk);
        rd(3'd4, 9, "R5 m active after wrap");
        rd(3'd5, 4, "R5 n active after wrap");

        // R3 and R2 base ratios
        wait_pulse(1'b1);
        @(posedge clk);
        repeat (3) push(1'b1, 10, "R3");
        wait_pulse(1'b0);
        @(posedge clk);
        repeat (3) push(1'b0, 5, "R2");
        drain();

        // R4: M staged, spacing unchanged
        wait_pulse(1'b1);
        wr(3'd0, 8'd5);
        repeat (3) push(1'b1, 10, "R4");
        rd(3'd4, 9, "R4 m active unchanged");
        rd(3'd6, 1, "R4 status m pending");
        drain();

        // R5: commit mid-period, no runt
        wait_pulse(1'b1);
        wr(3'd2, 8'h33);
        push(1'b1, 10, "R5 old period completes");
        push(1'b1, 6, "R5 new period");
        push(1'b1, 6, "R5 new period");
        rd(3'd4, 9, "R5 active still old");
        drain();
        rd(3'd4, 5, "R5 active new");

        // R6: DAC write with nothing pending
        wait_pulse(1'b1);
        wr(3'd2, 8'hC3);
        push(1'b1, 6, "R6");
        push(1'b1, 6, "R6");
        rd(3'd2, 'hC3, "R6 dac readback");
        check("R6 dac_code", int'(dac_code), 'hC3);
        rd(3'd4, 5, "R6 m active unchanged");
        drain();

        // R7: last write wins
        wr(3'd0, 8'd3);
        wr(3'd0, 8'd7);
        wr(3'd1, 8'd2);
        wr(3'd1, 8'd1);
        wait_pulse(1'b1);
        wr(3'd2, 8'h44);
        push(1'b1, 6, "R7 old");
        push(1'b1, 8, "R7 last M");
        push(1'b1, 8, "R7 last M");
        drain();
        wait_pulse(1'b0);
        @(posedge clk);
        push(1'b0, 2, "R7 last N");
        push(1'b0, 2, "R7 last N");
        drain();
        rd(3'd4, 7, "R7 m active");
        rd(3'd5, 1, "R7 n active");

        // R8: unmapped and read-only addresses ignore writes
        wr(3'd4, 8'h77);
        wr(3'd6, 8'hFF);
        wr(3'd3, 8'h11);
        wr(3'd7, 8'h22);
        wr(3'd5, 8'h66);
        rd(3'd4, 7, "R8 m active");
        rd(3'd5, 1, "R8 n active");
        rd(3'd6, 0, "R8 status");
        rd(3'd0, 7, "R8 m staged");
        rd(3'd2, 'h44, "R8 dac");
        rd(3'd3, 0, "R8 read addr3");
        rd(3'd7, 0, "R8 read addr7");
        wait_pulse(1'b1);
        @(posedge clk);
        push(1'b1, 8, "R8 spacing");
        drain();

        // R2: gated reference ticks
        gate_mode = 1'b1;
        repeat (10) @(negedge clk);
        wait_pulse(1'b0);
        @(posedge clk);
        push(1'b0, 4, "R2 gated");
        push(1'b0, 4, "R2 gated");
        drain();

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule